// File: doc/BRIEF.md
# Edge-Triggered Mid-Bit UART Receiver

This block receives asynchronous serial frames on one input line. A frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit. While the receiver is idle it watches the synchronized line for a falling edge. That edge arms a bit timer with a shortened first interval, so the first expiry lands near the centre of the start bit. Every later expiry is one full bit period after the previous one.

Once a frame has begun, the edge detector is blind to the line until the frame completes. At each timer expiry the block shifts one sample of the line into a register. After the tenth sample, the block judges the whole frame at once. A low start sample and a high stop sample make the frame good, and the received byte is presented with a one-cycle valid strobe. Any other combination gives a one-cycle framing-error strobe, and the byte output keeps its old value.

The receiver returns to idle at the centre of the stop bit. The remaining half bit is slack, so a start edge that arrives early still gets caught.

Top module: `mid_bit_uart_rx`

## Requirements
- R1: After reset, rx_valid_o and rx_frame_err_o are low and rx_data_o is zero, and a line held high produces no strobe.
- R2: In idle, a falling edge of rx_i starts a frame. The result strobe appears exactly 4 + (CLKS_PER_BIT/2 - 1) + 9*CLKS_PER_BIT clock cycles after the cycle in which the start level was first presented.
- R3: Ten samples are taken per frame, spaced CLKS_PER_BIT cycles apart, with the first at the centre of the start bit.
- R4: When the start sample is 0 and the stop sample is 1, rx_valid_o pulses for one cycle. rx_data_o then holds the eight data samples, with the first data sample in bit 0. rx_data_o changes only in that cycle.
- R5: A falling edge followed by a return to high before the start-bit centre produces a frame whose start sample is 1. That frame gives rx_frame_err_o and leaves rx_data_o unchanged.
- R6: A frame whose stop sample is 0 gives rx_frame_err_o and leaves rx_data_o unchanged.
- R7: Falling edges inside a frame, such as those of the data bits, do not restart acquisition or produce extra strobes.
- R8: The receiver re-arms at the stop-bit sample. A stop bit shortened to CLKS_PER_BIT/2 + 2 cycles, with the next start bit right after it, still yields a correct next frame.
- R9: rx_valid_o and rx_frame_err_o are never high together, and each lasts exactly one cycle per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| rx_data_o | output | DATA_BITS | Last good received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a good frame |
| rx_frame_err_o | output | 1 | One-cycle strobe for a bad start or stop sample |

## Verification
The bench builds the receiver with CLKS_PER_BIT of 8, so one frame takes 80 cycles. At that size, all 256 byte values fit in one run, sent back to back with full stop bits. The short period also makes the start-bit glitch, the low stop bit and a train of frames with half-length stop bits cheap to run. The bench works out the cycle of every strobe arithmetically from the bit period. It flags any strobe that arrives in another cycle as well as any strobe that is missing.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [0:0] {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

  function automatic logic frame_ok(input logic start_bit, input logic stop_bit);
    return (!start_bit) && stop_bit;
  endfunction

endpackage

// File: rtl/rx_sync_edge.sv
module rx_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic arm_i,
  output logic line_o,
  output logic fall_o
);

  // pipe[STAGES-1] is the synchronized line, pipe[STAGES] its previous value
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-1:0], rx_i};
  end

  assign line_o = pipe_q[STAGES-1];
  assign fall_o = arm_i && pipe_q[STAGES] && !pipe_q[STAGES-1];

endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned PRELOAD      = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  output logic tick_o
);

  localparam int unsigned CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LOAD_V   = CW'(PRELOAD);
  localparam logic [CW-1:0] RELOAD_V = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign tick_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= LOAD_V;
      run_q <= 1'b1;
    end else if (stop_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= (cnt_q == '0) ? RELOAD_V : cnt_q - 1'b1;
    end
  end

  assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  assert_no_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !run_q);

endmodule

// File: rtl/rx_frame_shift.sv
module rx_frame_shift #(
  parameter int unsigned FRAME_BITS = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  tick_i,
  input  logic                  bit_i,
  output logic                  done_o,
  output logic [FRAME_BITS-1:0] frame_o
);

  localparam int unsigned BW = $clog2(FRAME_BITS + 1);
  localparam logic [BW-1:0] FULL_V = BW'(FRAME_BITS);

  logic [BW-1:0]         left_q;
  logic [FRAME_BITS-2:0] shreg_q;

  assign done_o  = tick_i && (left_q == BW'(1));
  // full frame at the final tick, earliest sample in bit 0
  assign frame_o = {bit_i, shreg_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      shreg_q <= '0;
    end else if (load_i) begin
      left_q <= FULL_V;
    end else if (tick_i && left_q != '0) begin
      left_q  <= left_q - 1'b1;
      shreg_q <= {bit_i, shreg_q[FRAME_BITS-2:1]};
    end
  end

  assert_count_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= FULL_V);

  assert_load_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> left_q == '0);

endmodule

// File: rtl/mid_bit_uart_rx.sv
module mid_bit_uart_rx
  import uart_rx_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned DATA_BITS    = 8,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_i,
  output logic [DATA_BITS-1:0] rx_data_o,
  output logic                 rx_valid_o,
  output logic                 rx_frame_err_o
);

  localparam int unsigned FRAME_BITS = DATA_BITS + 2;
  localparam int unsigned START_LAT  = 1;  // edge-detect cycle before the timer runs
  localparam int unsigned PRELOAD    = CLKS_PER_BIT / 2 - START_LAT;

  rx_state_e             state_q;
  logic                  line;
  logic                  fall;
  logic                  tick;
  logic                  done;
  logic [FRAME_BITS-1:0] frame;

  rx_sync_edge #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .arm_i  (state_q == RX_IDLE),
    .line_o (line),
    .fall_o (fall)
  );

  rx_bit_timer #(
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .PRELOAD      (PRELOAD)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (fall),
    .stop_i  (done),
    .tick_o  (tick)
  );

  rx_frame_shift #(
    .FRAME_BITS (FRAME_BITS)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (fall),
    .tick_i  (tick),
    .bit_i   (line),
    .done_o  (done),
    .frame_o (frame)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   state_q <= RX_IDLE;
    else if (fall) state_q <= RX_BUSY;
    else if (done) state_q <= RX_IDLE;  // re-arm at mid stop bit
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o      <= '0;
      rx_valid_o     <= 1'b0;
      rx_frame_err_o <= 1'b0;
    end else begin
      rx_valid_o     <= 1'b0;
      rx_frame_err_o <= 1'b0;
      if (done) begin
        if (frame_ok(frame[0], frame[FRAME_BITS-1])) begin
          rx_valid_o <= 1'b1;
          rx_data_o  <= frame[FRAME_BITS-2:1];
        end else begin
          rx_frame_err_o <= 1'b1;
        end
      end
    end
  end

  assert_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_o && rx_frame_err_o));

  assert_valid_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_frame_err_o |=> !rx_frame_err_o);

  assert_data_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> $stable(rx_data_o));

  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> state_q == RX_BUSY);

  assert_rearm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> state_q == RX_IDLE);

endmodule

// File: tb/sim_mid_bit_uart_rx.sv
`timescale 1ns/1ps
module sim_mid_bit_uart_rx;

  localparam int CPB = 8;
  localparam int LAT = 4 + (CPB / 2 - 1) + 9 * CPB;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b1;
  logic [7:0] rx_data_o;
  logic       rx_valid_o;
  logic       rx_frame_err_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] last_good = 8'h00;

  int    exp_cyc[$];
  int    exp_kind[$];  // 0 good, 1 framing error
  int    exp_data[$];
  string exp_req[$];

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  mid_bit_uart_rx #(
    .CLKS_PER_BIT (CPB),
    .DATA_BITS    (8),
    .SYNC_STAGES  (2)
  ) u0 (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .rx_i           (rx_i),
    .rx_data_o      (rx_data_o),
    .rx_valid_o     (rx_valid_o),
    .rx_frame_err_o (rx_frame_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    rx_i = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_ev(input int kind, input int data, input string req);
    exp_cyc.push_back(cyc + LAT);
    exp_kind.push_back(kind);
    exp_data.push_back(data);
    exp_req.push_back(req);
  endtask

  task automatic send_byte(input logic [7:0] b, input int stop_len, input string req);
    expect_ev(0, int'(b), req);
    hold(1'b0, CPB);
    for (int i = 0; i < 8; i++) hold(b[i], CPB);
    hold(1'b1, stop_len);
  endtask

  // monitor: strobes only at predicted cycles (R2, R7, R9)
  always @(negedge clk) begin
    if (rst_ni) begin
      if (exp_cyc.size() != 0 && cyc == exp_cyc[0]) begin
        if (exp_kind[0] == 0) begin
          chk(rx_valid_o && !rx_frame_err_o, exp_req[0], {rx_valid_o, rx_frame_err_o}, 2'b10);
          chk(rx_data_o == 8'(exp_data[0]), exp_req[0], rx_data_o, exp_data[0]);
          last_good = 8'(exp_data[0]);
        end else begin
          chk(rx_frame_err_o && !rx_valid_o, exp_req[0], {rx_valid_o, rx_frame_err_o}, 2'b01);
          chk(rx_data_o == last_good, exp_req[0], rx_data_o, last_good);
        end
        void'(exp_cyc.pop_front());
        void'(exp_kind.pop_front());
        void'(exp_data.pop_front());
        void'(exp_req.pop_front());
      end else if (rx_valid_o || rx_frame_err_o) begin
        chk(1'b0, "R9 unexpected strobe", {rx_valid_o, rx_frame_err_o}, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(rx_valid_o == 1'b0, "R1", rx_valid_o, 0);
    chk(rx_frame_err_o == 1'b0, "R1", rx_frame_err_o, 0);
    chk(rx_data_o == 8'h00, "R1", rx_data_o, 0);
    hold(1'b1, 3 * CPB);

    // R2 R3 R4 R7: every byte back to back, data edges inside frames ignored
    for (int b = 0; b < 256; b++) send_byte(8'(b), CPB, "R4");
    hold(1'b1, 2 * CPB);
    send_byte(8'hAA, CPB, "R7");
    send_byte(8'h55, CPB, "R3");
    hold(1'b1, 2 * CPB);

    // R5: glitch start, sampled high at centre
    expect_ev(1, 0, "R5");
    hold(1'b0, 2);
    hold(1'b1, 10 * CPB + 2 * CPB);

    // R6: low stop bit
    expect_ev(1, 0, "R6");
    hold(1'b0, CPB);
    for (int i = 0; i < 8; i++) hold(logic'((8'h3C >> i) & 1), CPB);
    hold(1'b0, CPB);
    hold(1'b1, 3 * CPB);

    send_byte(8'hC3, CPB, "R4");
    hold(1'b1, CPB);

    // R8: shortened stop bits
    send_byte(8'h81, CPB / 2 + 2, "R8");
    send_byte(8'h7E, CPB / 2 + 2, "R8");
    send_byte(8'h19, CPB / 2 + 2, "R8");
    send_byte(8'hE4, CPB, "R8");
    hold(1'b1, 3 * CPB);

    chk(exp_cyc.size() == 0, "R2 missing strobe", exp_cyc.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule